// File: doc/BRIEF.md
# Serial Audio Transmit Channel with Mute and Word-Select Generator

This block takes audio samples from a transmit FIFO and shifts them out, most significant bit first, on the serial data line of a two-channel serial audio bus. Each word starts on the serial-clock falling edge that follows a change of word select. Low word select carries the left sample and high word select carries the right one. In stereo mode every word draws a fresh sample. In mono mode each sample is sent once with word select low and again with it high.

Word select has two possible sources, chosen by a control bit. In master mode a 9-bit counter counts serial-clock falling edges and inverts word select whenever it reaches the programmed half-period. In slave mode the block samples word select from an input. The channel runs on the system clock. The serial clock is an input that is sampled on that clock, and all bus actions take place on its detected falling edges. A mute control keeps the FIFO draining and replaces the data with zeros. A stop control blocks every FIFO access, silences the line and holds the word-select counter at zero.

Top module: `i2stx_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `sd_out`, `ws_out` and `fifo_ready` are all 0.
- R2: Each word carries its sample MSB first, starting in the first bit slot of the word. When the half-period is longer than SAMPLE_W, the extra slots at the end of the word are 0.
- R3: The first bit of a word is driven on the serial-clock falling edge after the one on which word select changed. `sd_out` changes only in the cycle after a detected falling edge, or when mute or stop is applied.
- R4: Stereo mode (`cfg_mono`=0) takes FIFO samples in order, one per word. Popping begins at a left word (word select 0) after reset or after stop is released, so the first sample of each pair goes out with word select low. A right word that comes before that first left word is sent as zeros.
- R5: Mono mode (`cfg_mono`=1) pops one sample at each left word and sends that same sample again in the following right word.
- R6: In master mode (`cfg_slave`=0) word select changes only on detected falling edges. It inverts every `cfg_half_period` falling edges (value 2 or more), which gives words of exactly that many bit slots.
- R7: In slave mode (`cfg_slave`=1), `ws_out` follows `ws_in` as sampled on falling edges, and word boundaries follow `ws_in`. `cfg_half_period` has no effect.
- R8: With `cfg_mute`=1, FIFO pops go on exactly as without mute, and `sd_out` is 0 from the next cycle on.
- R9: With `cfg_stop`=1, `fifo_ready` stays 0, `sd_out` is 0 and the word-select counter is held at zero, so in master mode `ws_out` does not change.
- R10: If the FIFO is empty when a word starts, that word is sent as zeros and the bus keeps running with unchanged word timing.
- R11: `fifo_ready` is asserted only in the cycle of a detected falling edge that starts a word. There is at most one pop per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock, sampled on clk |
| ws_in | input | 1 | Word select from the bus master (slave mode) |
| ws_out | output | 1 | Word select in effect (generated in master mode) |
| sd_out | output | 1 | Serial data, MSB first |
| fifo_valid | input | 1 | FIFO holds a sample |
| fifo_data | input | SAMPLE_W | Sample at the FIFO head |
| fifo_ready | output | 1 | Pop strobe; the sample is taken when valid is also high |
| cfg_slave | input | 1 | 1: word select from `ws_in`; 0: internal counter |
| cfg_mono | input | 1 | 1: each sample sent on both channels |
| cfg_stop | input | 1 | Blocks FIFO access, silences output, holds the counter |
| cfg_mute | input | 1 | Output forced to zero while the FIFO keeps draining |
| cfg_half_period | input | HALF_W | Bit slots per channel in master mode (2 or more) |

## Verification
Assertions check on every cycle the properties that hold cycle by cycle. Word select moves only on a falling edge. The data line moves only after a falling edge or a mute/stop change. Mute and stop zero the line, stop holds the counter at zero and blocks pops, pops fall only on edges and, in mono mode, only on left words. Word content and alignment can only be seen in the bench's scenarios, where a bus receiver model rebuilds words. These scenarios cover MSB-first order, stereo pairing and mono repetition, the zero tail when the half-period exceeds the sample width, underflow, and slave-mode tracking.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
    localparam int HALF_W_DEF   = 9;
    localparam int SAMPLE_W_DEF = 16;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2stx_edge.sv
module i2stx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic fall_o
);
    typedef struct packed {
        logic sck;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.sck = sck_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.sck & ~sck_i;
endmodule

// File: rtl/i2stx_wsgen.sv
module i2stx_wsgen #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              slave_i,
    input  logic              stop_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              ws_in_i,
    output logic              ws_o,
    output logic              ws_now_o,
    output logic              chg_o
);
    localparam int EXT_W = HALF_W + 1;

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              ws;
    } st_t;

    st_t  st_q, st_d;
    logic ws_now;
    logic chg;
    logic at_end;

    always_comb begin
        st_d   = st_q;
        ws_now = st_q.ws;
        chg    = 1'b0;
        at_end = ({1'b0, st_q.cnt} + EXT_W'(1)) >= {1'b0, half_i};
        if (fall_i) begin
            if (slave_i) begin
                ws_now   = ws_in_i;
                st_d.cnt = '0;
            end else if (stop_i) begin
                st_d.cnt = '0;
            end else if (at_end) begin
                st_d.cnt = '0;
                ws_now   = ~st_q.ws;
            end else begin
                st_d.cnt = st_q.cnt + HALF_W'(1);
            end
            st_d.ws = ws_now;
            chg     = (ws_now != st_q.ws);
        end
        if (stop_i) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ws_o     = st_q.ws;
    assign ws_now_o = ws_now;
    assign chg_o    = chg;

    // R9
    stop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st_q.cnt == '0));

    // R6
    ws_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(st_q.ws));
endmodule

// File: rtl/i2stx_shifter.sv
module i2stx_shifter
    import i2stx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_i,
    input  logic                chg_i,
    input  logic                ws_now_i,
    input  logic                mono_i,
    input  logic                stop_i,
    input  logic                mute_i,
    input  logic                fifo_valid_i,
    input  logic [SAMPLE_W-1:0] fifo_data_i,
    output logic                fifo_ready_o,
    output logic                sd_o
);
    typedef struct packed {
        logic                pend;
        chan_e               chan;
        logic                sync;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] sh;
        logic                sd;
    } st_t;

    st_t                 st_q, st_d;
    logic                take;
    logic                bit_out;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        st_d    = st_q;
        take    = 1'b0;
        bit_out = st_q.sh[SAMPLE_W-1];
        word    = '0;
        if (fall_i) begin
            if (st_q.pend) begin
                if (mono_i) begin
                    take = !stop_i && (st_q.chan == CH_LEFT);
                    if (st_q.chan == CH_LEFT) begin
                        word      = (take && fifo_valid_i) ? fifo_data_i : '0;
                        st_d.hold = word;
                    end else begin
                        word = stop_i ? '0 : st_q.hold;
                    end
                end else begin
                    take = !stop_i && ((st_q.chan == CH_LEFT) || st_q.sync);
                    word = (take && fifo_valid_i) ? fifo_data_i : '0;
                end
                if (st_q.chan == CH_LEFT) st_d.sync = 1'b1;
                bit_out = word[SAMPLE_W-1];
                st_d.sh = {word[SAMPLE_W-2:0], 1'b0};
            end else begin
                st_d.sh = {st_q.sh[SAMPLE_W-2:0], 1'b0};
            end
            st_d.pend = chg_i;
            if (chg_i) st_d.chan = ws_now_i ? CH_RIGHT : CH_LEFT;
            st_d.sd = bit_out;
        end
        if (stop_i) begin
            st_d.sync = 1'b0;
            st_d.hold = '0;
        end
        if (stop_i || mute_i) st_d.sd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_ready_o = take;
    assign sd_o         = st_q.sd;

    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_i || stop_i) |=> !st_q.sd);

    // R9
    stop_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !fifo_ready_o);

    // R5
    mono_left_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_i && fifo_ready_o) |-> (st_q.chan == CH_LEFT));
endmodule

// File: rtl/i2stx_top.sv
module i2stx_top
    import i2stx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int HALF_W   = HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_i,
    input  logic                ws_in,
    output logic                ws_out,
    output logic                sd_out,
    input  logic                fifo_valid,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                fifo_ready,
    input  logic                cfg_slave,
    input  logic                cfg_mono,
    input  logic                cfg_stop,
    input  logic                cfg_mute,
    input  logic [HALF_W-1:0]   cfg_half_period
);
    logic fall_w;
    logic ws_now_w;
    logic chg_w;

    i2stx_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .fall_o (fall_w)
    );

    i2stx_wsgen #(.HALF_W(HALF_W)) wsgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall_w),
        .slave_i  (cfg_slave),
        .stop_i   (cfg_stop),
        .half_i   (cfg_half_period),
        .ws_in_i  (ws_in),
        .ws_o     (ws_out),
        .ws_now_o (ws_now_w),
        .chg_o    (chg_w)
    );

    i2stx_shifter #(.SAMPLE_W(SAMPLE_W)) shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall_w),
        .chg_i        (chg_w),
        .ws_now_i     (ws_now_w),
        .mono_i       (cfg_mono),
        .stop_i       (cfg_stop),
        .mute_i       (cfg_mute),
        .fifo_valid_i (fifo_valid),
        .fifo_data_i  (fifo_data),
        .fifo_ready_o (fifo_ready),
        .sd_o         (sd_out)
    );

    // R11
    pop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ready |-> fall_w);

    // R3
    sd_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_w && !cfg_mute && !cfg_stop) |=> $stable(sd_out));
endmodule

// File: tb/i2stx_top_tb_top.sv
module i2stx_top_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         ws_in = 1'b0;
    logic         cfg_slave = 1'b0, cfg_mono = 1'b0, cfg_stop = 1'b0, cfg_mute = 1'b0;
    logic [8:0]   cfg_half = 9'd16;
    logic         fifo_valid = 1'b0;
    logic [W-1:0] fifo_data = '0;
    logic         fifo_ready, sd_out, ws_out;

    always #2 clk = ~clk;

    i2stx_top #(.SAMPLE_W(W), .HALF_W(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_in(ws_in), .ws_out(ws_out),
        .sd_out(sd_out), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_ready(fifo_ready), .cfg_slave(cfg_slave), .cfg_mono(cfg_mono),
        .cfg_stop(cfg_stop), .cfg_mute(cfg_mute), .cfg_half_period(cfg_half)
    );

    int errs = 0, checks = 0;
    logic [W-1:0] samples [16];
    int  n_ld = 0, rd_idx = 0, pops = 0;
    logic fire = 1'b0;
    logic sck_run = 1'b0;
    int  div = 0, slv_half = 18, slv_cnt = 0;
    int  cyc = 0;

    logic [W-1:0] rx_val [64];
    logic         rx_chan [64];
    logic         rx_tail [64];
    int           rx_nb [64];
    int  rx_n = 0, cur_nb = 0, ones = 0, ws_toggles = 0;
    logic [W-1:0] cur_val = '0;
    logic cur_tail = 1'b1, prev_ws = 1'b0, prev_sck = 1'b0, prev_wso = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial clock, slave word select and FIFO model, driven 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            rd_idx = 0; div = 0; slv_cnt = 0; sck = 1'b0; ws_in = 1'b0;
        end else begin
            if (fire) rd_idx++;
            if (sck_run) begin
                div++;
                if (div == 4) begin
                    div = 0;
                    sck = ~sck;
                    if (!sck) begin
                        slv_cnt++;
                        if (slv_cnt == slv_half) begin
                            slv_cnt = 0;
                            ws_in = ~ws_in;
                        end
                    end
                end
            end
        end
        fifo_valid = (rd_idx < n_ld);
        fifo_data  = (rd_idx < n_ld && rd_idx < 16) ? samples[rd_idx] : '0;
    end

    // receiver model and pop counter, sampled at the falling clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            fire = 1'b0; pops = 0; rx_n = 0; cur_nb = 0; cur_val = '0; cur_tail = 1'b1;
            ones = 0; ws_toggles = 0; prev_ws = 1'b0; prev_sck = 1'b0; prev_wso = 1'b0;
        end else begin
            fire = fifo_valid && fifo_ready;
            if (fire) pops++;
            if (sd_out) ones++;
            if (ws_out != prev_wso) ws_toggles++;
            prev_wso = ws_out;
            if (sck && !prev_sck) begin
                if (cur_nb < W) cur_val = {cur_val[W-2:0], sd_out};
                else if (sd_out) cur_tail = 1'b0;
                cur_nb++;
                if (ws_out != prev_ws) begin
                    if (rx_n < 64) begin
                        rx_val[rx_n] = cur_val; rx_chan[rx_n] = prev_ws;
                        rx_tail[rx_n] = cur_tail; rx_nb[rx_n] = cur_nb;
                    end
                    rx_n++;
                    cur_nb = 0; cur_val = '0; cur_tail = 1'b1;
                end
                prev_ws = ws_out;
            end
            prev_sck = sck;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic restart(input bit slave, input bit mono, input bit stop, input bit mute,
                           input int half, input int nsamp, input int base);
        rst_n = 1'b0;
        sck_run = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        cfg_slave = slave; cfg_mono = mono; cfg_stop = stop; cfg_mute = mute;
        cfg_half = 9'(half);
        for (int i = 0; i < 16; i++) samples[i] = W'(base + 16'h1111 * i + 16'h0A05);
        n_ld = nsamp;
        rst_n = 1'b1;
        sck_run = 1'b1;
    endtask

    task automatic wait_words(input int n);
        while (rx_n < n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sd_out == 0 && ws_out == 0 && fifo_ready == 0, "R1 reset outputs",
            {sd_out, ws_out, fifo_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_out == 0 && ws_out == 0 && fifo_ready == 0, "R1 after release",
            {sd_out, ws_out, fifo_ready}, 0);
    endtask

    task automatic t_stereo;
        restart(0, 0, 0, 0, 16, 6, 16'h1234);
        wait_words(8);
        chk(rx_val[1] == 0, "R4 right before first left is zero", rx_val[1], 0);
        for (int k = 0; k < 6; k++) begin
            chk(rx_val[2+k] == samples[k] && rx_chan[2+k] == (k % 2),
                "R2 R4 stereo word order", rx_val[2+k], samples[k]);
        end
        for (int k = 1; k < 8; k++)
            chk(rx_nb[k] == 16, "R6 R3 word length", rx_nb[k], 16);
        chk(pops == 6, "R11 one pop per word", pops, 6);
    endtask

    task automatic t_mono;
        restart(0, 1, 0, 0, 16, 3, 16'h5A00);
        wait_words(8);
        for (int k = 0; k < 3; k++) begin
            chk(rx_val[2+2*k] == samples[k] && rx_chan[2+2*k] == 0, "R5 mono left", rx_val[2+2*k], samples[k]);
            chk(rx_val[3+2*k] == samples[k] && rx_chan[3+2*k] == 1, "R5 mono right repeat", rx_val[3+2*k], samples[k]);
        end
        chk(pops == 3, "R5 one pop per frame", pops, 3);
    endtask

    task automatic t_long_half;
        restart(0, 0, 0, 0, 20, 4, 16'h8001);
        wait_words(6);
        for (int k = 0; k < 4; k++) begin
            chk(rx_val[2+k] == samples[k], "R2 word with long half-period", rx_val[2+k], samples[k]);
            chk(rx_tail[2+k] == 1'b1, "R2 tail slots zero", rx_tail[2+k], 1);
            chk(rx_nb[2+k] == 20, "R6 slots per word", rx_nb[2+k], 20);
        end
    endtask

    task automatic t_mute;
        restart(0, 0, 0, 1, 16, 4, 16'hFFF0);
        wait_words(6);
        chk(ones == 0, "R8 muted line stays zero", ones, 0);
        chk(pops == 4, "R8 pops continue under mute", pops, 4);
    endtask

    task automatic t_stop;
        restart(0, 0, 1, 0, 16, 4, 16'h3C3C);
        repeat (1200) @(posedge clk);
        @(negedge clk);
        chk(pops == 0, "R9 no pops while stopped", pops, 0);
        chk(ws_toggles == 0, "R9 counter held, ws still", ws_toggles, 0);
        chk(ones == 0, "R9 line silent", ones, 0);
        cfg_stop = 1'b0;
        wait_words(4);
        chk(rx_val[2] == samples[0] && rx_val[3] == samples[1], "R9 resume after stop",
            rx_val[2], samples[0]);
    endtask

    task automatic t_underflow;
        restart(0, 0, 0, 0, 16, 2, 16'h7E81);
        wait_words(8);
        chk(rx_val[2] == samples[0] && rx_val[3] == samples[1], "R10 data before underflow",
            rx_val[3], samples[1]);
        for (int k = 4; k < 8; k++) begin
            chk(rx_val[k] == 0, "R10 empty FIFO sends zeros", rx_val[k], 0);
            chk(rx_nb[k] == 16, "R10 timing unchanged", rx_nb[k], 16);
        end
    endtask

    task automatic t_slave;
        slv_half = 18;
        restart(1, 0, 0, 0, 3, 4, 16'h0F0F);
        wait_words(6);
        for (int k = 1; k < 6; k++)
            chk(rx_nb[k] == 18, "R7 words follow ws_in", rx_nb[k], 18);
        for (int k = 0; k < 4; k++)
            chk(rx_val[2+k] == samples[k], "R7 slave data", rx_val[2+k], samples[k]);
    endtask

    initial begin
        t_reset();
        t_stereo();
        t_mono();
        t_long_half();
        t_mute();
        t_stop();
        t_underflow();
        t_slave();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule